// File: doc/BRIEF.md
# Radio Receive Frame Fetcher

This block sits on the host side of a serial-attached packet radio and drains one received frame each time the radio signals that its receive queue has crossed its threshold. A rising edge on the threshold pin starts a fetch. The block first looks at the level of the queue-status pin: a low level means the radio's receive queue overflowed, and nothing is read. Otherwise the block issues a short read command that returns only the frame length byte, and checks that length against a legal window. If the length is legal, a second read command pulls the whole frame. Every byte except the two trailing checksum bytes goes into a local buffer through a simple write port.

Each fetch ends the same way, whether it succeeded, was rejected or hit an overflow: two separate flush commands clear the radio's receive queue. A successful fetch raises a one-cycle frame-valid pulse that carries the stored byte count. The block talks to the radio through a byte-level serial engine. It frames each command with an active-low select and hands the engine one byte at a time with a start pulse. The engine answers each byte with a done pulse and the byte it received.

Top module: `rx_frame_fetch`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `sel_n` is 1 and `byte_go`, `buf_we` and `frame_ok` are 0.
- R2: A fetch starts only on a 0-to-1 transition of `thr_pin`, seen after the input synchronizer. Holding `thr_pin` high starts no further fetch.
- R3: If `qstat_pin` is 0 when a fetch starts, the block counts it as an overflow. It issues no read command and goes straight to the two flush commands.
- R4: The first command of a non-overflow fetch is a select-framed transaction of exactly 2 bytes: the read opcode 0x30 and then one byte whose received value is the frame length.
- R5: A length below 2 or above 127 is rejected. No second read command follows, nothing is written to the buffer and `frame_ok` stays 0.
- R6: A legal length L leads to a second transaction with opcode 0x30 that is L+1 bytes long: the opcode and then L data bytes.
- R7: Of the L data bytes, the first L-2 are written to the buffer in arrival order at addresses 0 to L-3. The last 2 bytes are the checksum and are never written.
- R8: After a successful payload read, `frame_ok` is high for exactly one cycle and `frame_len` equals L-2 in that cycle. In that same cycle the first flush command starts.
- R9: Every fetch ends with two separate 1-byte transactions, each carrying the flush opcode 0x47. This holds on the success, reject and overflow paths alike.
- R10: A rising edge of `thr_pin` that arrives while a fetch is in progress is held pending and starts one new fetch after the second flush. Several such edges collapse into one pending fetch.
- R11: `byte_go` is raised only while `sel_n` is 0. `sel_n` returns to 1 for at least one cycle between two transactions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr_pin | input | 1 | Receive threshold pin from the radio, asynchronous |
| qstat_pin | input | 1 | Receive queue status pin (low means overflow), asynchronous |
| sel_n | output | 1 | Active-low transaction select to the serial engine |
| byte_go | output | 1 | One-cycle start of a byte exchange |
| byte_tx | output | 8 | Byte to send |
| byte_done | input | 1 | One-cycle pulse when the exchange finishes |
| byte_rx | input | 8 | Byte received, valid with byte_done |
| buf_we | output | 1 | Buffer write enable |
| buf_addr | output | 7 | Buffer write address |
| buf_wdata | output | 8 | Buffer write data |
| frame_ok | output | 1 | One-cycle frame-valid pulse |
| frame_len | output | 8 | Stored byte count, valid with frame_ok |

## Verification
A wrong phase or byte counter in the sequencer shows up at the serial port within one transaction. The select window then holds the wrong number of byte exchanges, or the wrong opcode opens a command, or a flush is missing when select rises. A length window that is off by one shows up at the boundary lengths 1, 2, 127 and 128: an unexpected payload transaction appears, or one that should be there is missing, before the next select edge. Errors in the checksum trim or in the address count show up on the very write cycle, because each write is compared against the expected address and byte as it happens. A lost pending trigger shows up as a missing second fetch once the first fetch's flushes have finished.

// File: rtl/rff_pkg.sv
package rff_pkg;
  localparam int BW = 8;
  localparam logic [BW-1:0] OP_RXREAD  = 8'h30;
  localparam logic [BW-1:0] OP_RXFLUSH = 8'h47;
  localparam logic [BW-1:0] OP_DUMMY   = 8'h00;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LEN,
    PH_PAY,
    PH_FL1,
    PH_FL2
  } phase_t;
endpackage

// File: rtl/rff_trigger.sv
module rff_trigger #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic thr_async,
  input  logic qstat_async,
  input  logic take,
  output logic pend,
  output logic qstat_lvl
);
  logic [SYNC_STAGES-1:0] thr_s, qst_s;
  logic thr_prev;
  logic rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_s    <= '0;
      qst_s    <= '0;
      thr_prev <= 1'b0;
    end else begin
      thr_s    <= {thr_s[SYNC_STAGES-2:0], thr_async};
      qst_s    <= {qst_s[SYNC_STAGES-2:0], qstat_async};
      thr_prev <= thr_s[SYNC_STAGES-1];
    end
  end

  assign rise      = thr_s[SYNC_STAGES-1] & ~thr_prev;
  assign qstat_lvl = qst_s[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst)       pend <= 1'b0;
    else if (rise) pend <= 1'b1;
    else if (take) pend <= 1'b0;
  end

  // R10
  pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pend && !take) |=> pend);

  // R2
  edge_latch_chk: assert property (@(posedge clk) disable iff (rst)
    rise |=> pend);
endmodule

// File: rtl/rff_seq.sv
module rff_seq
  import rff_pkg::*;
#(
  parameter int MIN_LEN = 2,
  parameter int MAX_LEN = 127,
  parameter int FCS_LEN = 2,
  localparam int AW = $clog2(MAX_LEN),
  localparam int CW = BW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pend,
  input  logic          qstat_lvl,
  output logic          take,
  output logic          sel_n,
  output logic          go,
  output logic [BW-1:0] tx,
  input  logic          done,
  input  logic [BW-1:0] rx,
  output logic          we,
  output logic [AW-1:0] addr,
  output logic [BW-1:0] wdata,
  output logic          ok,
  output logic [BW-1:0] len_out
);
  localparam logic [BW-1:0] MIN_B = BW'(MIN_LEN);
  localparam logic [BW-1:0] MAX_B = BW'(MAX_LEN);

  phase_t        phase, nxt_phase;
  logic [CW-1:0] bcnt, total, nxt_total, didx;
  logic [BW-1:0] len_q, nxt_op;
  logic          start_en, len_ok;

  assign len_ok = (len_q >= MIN_B) && (len_q <= MAX_B);
  assign take   = (phase == PH_IDLE) && pend;
  assign didx   = bcnt - CW'(1);

  always_comb begin
    start_en  = 1'b0;
    nxt_phase = phase;
    nxt_op    = OP_RXFLUSH;
    nxt_total = CW'(1);
    if (phase == PH_IDLE) begin
      if (pend) begin
        start_en = 1'b1;
        if (qstat_lvl) begin
          nxt_phase = PH_LEN;
          nxt_op    = OP_RXREAD;
          nxt_total = CW'(2);
        end else begin
          nxt_phase = PH_FL1;
        end
      end
    end else if (sel_n) begin
      case (phase)
        PH_LEN: begin
          start_en = 1'b1;
          if (len_ok) begin
            nxt_phase = PH_PAY;
            nxt_op    = OP_RXREAD;
            nxt_total = CW'(len_q) + CW'(1);
          end else begin
            nxt_phase = PH_FL1;
          end
        end
        PH_PAY: begin
          start_en  = 1'b1;
          nxt_phase = PH_FL1;
        end
        PH_FL1: begin
          start_en  = 1'b1;
          nxt_phase = PH_FL2;
        end
        default: nxt_phase = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      sel_n   <= 1'b1;
      go      <= 1'b0;
      tx      <= '0;
      bcnt    <= '0;
      total   <= '0;
      len_q   <= '0;
      we      <= 1'b0;
      addr    <= '0;
      wdata   <= '0;
      ok      <= 1'b0;
      len_out <= '0;
    end else begin
      go    <= 1'b0;
      we    <= 1'b0;
      ok    <= 1'b0;
      phase <= nxt_phase;
      if (phase == PH_PAY && sel_n) begin
        ok      <= 1'b1;
        len_out <= len_q - BW'(FCS_LEN);
      end
      if (start_en) begin
        sel_n <= 1'b0;
        go    <= 1'b1;
        tx    <= nxt_op;
        bcnt  <= '0;
        total <= nxt_total;
      end else if (!sel_n && done) begin
        bcnt <= bcnt + CW'(1);
        if (bcnt != '0) begin
          if (phase == PH_LEN) len_q <= rx;
          if (phase == PH_PAY && didx < CW'(len_q) - CW'(FCS_LEN)) begin
            we    <= 1'b1;
            addr  <= didx[AW-1:0];
            wdata <= rx;
          end
        end
        if (bcnt + CW'(1) == total) begin
          sel_n <= 1'b1;
        end else begin
          go <= 1'b1;
          tx <= OP_DUMMY;
        end
      end
    end
  end

  // R11
  go_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    go |-> !sel_n);

  // R11
  frame_opens_with_go_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sel_n) |-> go);

  // R8
  ok_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ok |=> !ok);

  // R8
  ok_then_flush_chk: assert property (@(posedge clk) disable iff (rst)
    ok |-> (go && tx == OP_RXFLUSH));

  // R7
  we_in_payload_chk: assert property (@(posedge clk) disable iff (rst)
    we |-> (phase == PH_PAY));

  // R5
  we_legal_len_chk: assert property (@(posedge clk) disable iff (rst)
    we |-> (len_q >= MIN_B && len_q <= MAX_B));
endmodule

// File: rtl/rx_frame_fetch.sv
module rx_frame_fetch #(
  parameter int MIN_LEN     = 2,
  parameter int MAX_LEN     = 127,
  parameter int FCS_LEN     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       thr_pin,
  input  logic       qstat_pin,
  output logic       sel_n,
  output logic       byte_go,
  output logic [7:0] byte_tx,
  input  logic       byte_done,
  input  logic [7:0] byte_rx,
  output logic       buf_we,
  output logic [6:0] buf_addr,
  output logic [7:0] buf_wdata,
  output logic       frame_ok,
  output logic [7:0] frame_len
);
  logic pend, take, qstat_lvl;

  rff_trigger #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
    .clk(clk), .rst(rst), .thr_async(thr_pin), .qstat_async(qstat_pin),
    .take(take), .pend(pend), .qstat_lvl(qstat_lvl)
  );

  rff_seq #(.MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN), .FCS_LEN(FCS_LEN)) u_seq (
    .clk(clk), .rst(rst), .pend(pend), .qstat_lvl(qstat_lvl), .take(take),
    .sel_n(sel_n), .go(byte_go), .tx(byte_tx), .done(byte_done), .rx(byte_rx),
    .we(buf_we), .addr(buf_addr), .wdata(buf_wdata),
    .ok(frame_ok), .len_out(frame_len)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (sel_n && !byte_go && !buf_we && !frame_ok));
endmodule

// File: tb/tb_rx_frame_fetch.sv
`timescale 1ns/1ps
module tb_rx_frame_fetch;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic thr_pin = 1'b0, qstat_pin = 1'b1;
  logic sel_n, byte_go, byte_done = 1'b0, buf_we, frame_ok;
  logic [7:0] byte_tx, byte_rx = 8'h00, buf_wdata, frame_len;
  logic [6:0] buf_addr;

  always #2 clk = ~clk;

  rx_frame_fetch dut (
    .clk(clk), .rst(rst), .thr_pin(thr_pin), .qstat_pin(qstat_pin),
    .sel_n(sel_n), .byte_go(byte_go), .byte_tx(byte_tx),
    .byte_done(byte_done), .byte_rx(byte_rx),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
    .frame_ok(frame_ok), .frame_len(frame_len)
  );

  int checks = 0, errors = 0;
  byte unsigned radio_q[$];
  int exp_op[$], exp_n[$], exp_wa[$], exp_wd[$], exp_len[$];
  string exp_tag[$];
  int cnt = 0, tx_idx = 0, cur_op = 0;
  logic [7:0] resp = 8'h00;
  logic prev_sel = 1'b1, prev_ok = 1'b0;

  task automatic chk(input bit good, input string tag, input int act, input int exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push_tr(input int op, input int n, input string tag);
    exp_op.push_back(op);
    exp_n.push_back(n);
    exp_tag.push_back(tag);
  endtask

  // Expected traffic of one fetch, built from the requirements.
  task automatic exp_fetch(input int len, input int seed, input bit ovf);
    string ft;
    ft = ovf ? "R3 overflow flush R9" : "R9 flush";
    if (!ovf) begin
      push_tr(8'h30, 2, "R4 length read");
      radio_q.push_back(8'(len));
      if (len >= 2 && len <= 127) begin
        push_tr(8'h30, len + 1, "R6 payload read");
        for (int i = 0; i < len; i++) begin
          radio_q.push_back(8'((seed + 7 * i) & 255));
          if (i < len - 2) begin
            exp_wa.push_back(i);
            exp_wd.push_back((seed + 7 * i) & 255);
          end
        end
        exp_len.push_back(len - 2);
      end else begin
        ft = "R5 reject then R9 flush";
      end
    end
    push_tr(8'h47, 1, ft);
    push_tr(8'h47, 1, ft);
  endtask

  // Serial engine model and per-clock comparison.
  always @(negedge clk) begin
    byte_done <= 1'b0;
    if (cnt > 0) begin
      cnt--;
      if (cnt == 0) begin
        byte_done <= 1'b1;
        byte_rx   <= resp;
      end
    end
    if (!rst) begin
      if (prev_sel && !sel_n) tx_idx = 0;
      if (!prev_sel && sel_n) begin
        if (exp_op.size() == 0) chk(1'b0, "R2 unexpected transaction", cur_op, -1);
        else begin
          string t; int eo; int en;
          t = exp_tag.pop_front(); eo = exp_op.pop_front(); en = exp_n.pop_front();
          chk(cur_op == eo, {t, " opcode"}, cur_op, eo);
          chk(tx_idx == en, {t, " byte count"}, tx_idx, en);
        end
      end
      if (byte_go) begin
        if (sel_n) chk(1'b0, "R11 byte start outside select", 1, 0);
        if (tx_idx == 0) cur_op = int'(byte_tx);
        if (tx_idx > 0 && cur_op == 8'h30)
          resp = (radio_q.size() > 0) ? radio_q.pop_front() : 8'h00;
        else
          resp = 8'h00;
        tx_idx++;
        cnt = LAT;
      end
      if (buf_we) begin
        if (exp_wa.size() == 0) chk(1'b0, "R7 unexpected buffer write", int'(buf_addr), -1);
        else begin
          int ea; int ed;
          ea = exp_wa.pop_front(); ed = exp_wd.pop_front();
          chk(int'(buf_addr) == ea, "R7 write address", int'(buf_addr), ea);
          chk(int'(buf_wdata) == ed, "R7 write data", int'(buf_wdata), ed);
        end
      end
      if (frame_ok) begin
        if (prev_ok) chk(1'b0, "R8 frame_ok wider than one cycle", 2, 1);
        if (exp_len.size() == 0) chk(1'b0, "R8 unexpected frame_ok", int'(frame_len), -1);
        else begin
          int el;
          el = exp_len.pop_front();
          chk(int'(frame_len) == el, "R8 frame_len", int'(frame_len), el);
        end
      end
    end
    prev_sel = sel_n;
    prev_ok  = frame_ok;
  end

  task automatic settle(input int n, input string tag);
    repeat (n) @(negedge clk);
    chk(exp_op.size() == 0, {tag, " missing transactions"}, exp_op.size(), 0);
    chk(exp_wa.size() == 0, {tag, " missing writes"}, exp_wa.size(), 0);
    chk(exp_len.size() == 0, {tag, " missing frame_ok"}, exp_len.size(), 0);
  endtask

  task automatic one_fetch(input int len, input bit ovf, input string tag);
    exp_fetch(len, len * 3 + 1, ovf);
    @(negedge clk);
    qstat_pin = !ovf;
    @(negedge clk);
    thr_pin = 1'b1;
    settle(1500, tag);
    thr_pin = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: quiet outputs in reset
    chk(sel_n == 1'b1, "R1 sel_n in reset", int'(sel_n), 1);
    chk(byte_go == 1'b0, "R1 byte_go in reset", int'(byte_go), 0);
    chk(buf_we == 1'b0 && frame_ok == 1'b0, "R1 write/valid in reset",
        int'(buf_we) + int'(frame_ok), 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);

    one_fetch(10, 1'b0, "R6 good frame, R2 level held");
    one_fetch(0, 1'b1, "R3 overflow");
    one_fetch(1, 1'b0, "R5 length 1");
    one_fetch(128, 1'b0, "R5 length 128");
    one_fetch(255, 1'b0, "R5 length 255");
    one_fetch(2, 1'b0, "R7 length 2");
    one_fetch(127, 1'b0, "R7 length 127");
    one_fetch(3, 1'b0, "R8 length 3");

    // R10: edges during a fetch collapse into one pending fetch
    exp_fetch(20, 11, 1'b0);
    exp_fetch(5, 90, 1'b0);
    qstat_pin = 1'b1;
    @(negedge clk);
    thr_pin = 1'b1;
    repeat (30) @(negedge clk);
    thr_pin = 1'b0;
    repeat (3) @(negedge clk);
    thr_pin = 1'b1;
    repeat (3) @(negedge clk);
    thr_pin = 1'b0;
    repeat (3) @(negedge clk);
    thr_pin = 1'b1;
    repeat (3) @(negedge clk);
    thr_pin = 1'b0;
    settle(3000, "R10 pending fetch");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule